// File: doc/BRIEF.md
# Self-Arbitrating Crossbar Fabric

The fabric connects `N_IN` source ports to `N_OUT` destination ports. Every destination column carries its own arbiter and a row of one-bit connection latches, one per source. A source asks for a column by raising the request bit for that column. When the column is free, the arbiter picks one requester in a single cycle, sets that source's latch and returns a one-cycle grant pulse to it. The connection stays in place until the owner raises the matching release bit. At that edge the latch clears and the winner falls to the bottom of the column's priority order, so the column's priority list follows a least-recently-granted rule.

Each column's output word is the OR of the data words of all sources whose latch is set on that column. The arbiter keeps at most one latch set per column, so the output is the owner's word, or zero when nobody owns the column. One source may own several columns at once. This gives multicast, and broadcast when it owns them all. Columns never interact: each one arbitrates, holds and releases on its own.

Request, release and grant are flat vectors. The bit for source `i` and column `o` sits at index `i*N_OUT + o`.

Top module: `xbar_fabric`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no column is connected, every `out_data_o` word is zero and `gnt_o` is zero.
- R2: A request to a free column in cycle t is arbitrated within that cycle. From the clock edge that ends cycle t, `gnt_o` shows a pulse to the winner for exactly one cycle, and the column outputs the winner's data.
- R3: At most one source owns a column. A connected column outputs the owner's `in_data_o` word combinationally. An unconnected column outputs all zeros.
- R4: Columns are independent: different sources can hold different columns at the same time, each column showing its own owner's data.
- R5: One source can win and hold several columns at once (multicast). Every such column outputs that source's data.
- R6: A connection persists after the owner drops its request, until the owner releases it.
- R7: A release from the owner in cycle t clears the connection at the end of cycle t. The column outputs zero from then on. A competing request present during cycle t is not granted at that edge, and can be granted no earlier than the following edge.
- R8: A request to a column held by another source has no effect: no grant, and the data stays the owner's. A release bit from a non-owner has no effect.
- R9: After reset, a lower source index beats a higher one. When a source releases a column, it becomes that column's lowest priority. The priority order changes only at release, never at grant.
- R10: Request, release and grant bit `i*N_OUT + o` refers to source `i` and column `o`. Output word `o` sits at bits `o*DW +: DW` and source word `i` at bits `i*DW +: DW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | N_IN*DW | Data word of each source |
| req_i | input | N_IN*N_OUT | Per source and column request |
| rel_i | input | N_IN*N_OUT | Per source and column release |
| gnt_o | output | N_IN*N_OUT | One-cycle grant acknowledgement |
| out_data_o | output | N_OUT*DW | Merged data word of each column |

## Verification
Release and arbitration can meet on the same column in one cycle: the owner raises its release bit while another source is requesting that column. The bench provokes this directly, and also through random, dense request and release traffic. It judges the result against a behavioural model that keeps an owner and an ordered priority list per column. Both the bench and the model require the column to read zero with no grant at the release edge, and the waiting source to be granted exactly one edge later. The bench also checks that the new priority order already applies to that grant.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  // flat position of the (source, column) bit
  function automatic int unsigned pair_idx(input int unsigned src, input int unsigned col,
                                           input int unsigned n_col);
    return src * n_col + col;
  endfunction
endpackage

// File: rtl/xbar_lrg_order.sv
`timescale 1ns/1ps
module xbar_lrg_order #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] demote_i,     // one-hot: source that just released
  output logic [N_IN-1:0] beats_o [N_IN] // beats_o[a][b]: a outranks b
);
  logic [N_IN-1:0] beats_q [N_IN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < N_IN; a++)
        for (int b = 0; b < N_IN; b++)
          beats_q[a][b] <= (a < b);
    end else if (|demote_i) begin
      for (int a = 0; a < N_IN; a++)
        for (int b = 0; b < N_IN; b++)
          if (a != b) begin
            if (demote_i[a])      beats_q[a][b] <= 1'b0;
            else if (demote_i[b]) beats_q[a][b] <= 1'b1;
          end
    end
  end

  assign beats_o = beats_q;

  // R9: order stays a strict total order
  for (genvar a = 0; a < N_IN; a++) begin : g_a
    for (genvar b = a + 1; b < N_IN; b++) begin : g_b
      // R9
      order_antisym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beats_q[a][b] != beats_q[b][a]);
    end
  end
endmodule

// File: rtl/xbar_col_arb.sv
`timescale 1ns/1ps
module xbar_col_arb #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] req_i,
  input  logic [N_IN-1:0] rel_i,
  output logic [N_IN-1:0] own_o,
  output logic [N_IN-1:0] gnt_o
);
  logic [N_IN-1:0] own_q, gnt_q, win, rel_hit;
  logic [N_IN-1:0] beats [N_IN];
  logic            busy;

  assign busy    = |own_q;
  assign rel_hit = own_q & rel_i;

  xbar_lrg_order #(.N_IN(N_IN)) u_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .demote_i(rel_hit),
    .beats_o (beats)
  );

  // a wins when no other requester outranks it
  always_comb begin
    for (int a = 0; a < N_IN; a++) begin
      win[a] = req_i[a];
      for (int b = 0; b < N_IN; b++)
        if (req_i[b] && beats[b][a]) win[a] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
      gnt_q <= '0;
    end else begin
      gnt_q <= '0;
      if (!busy) begin
        own_q <= win;
        gnt_q <= win;
      end else if (|rel_hit) begin
        own_q <= '0;
      end
    end
  end

  assign own_o = own_q;
  assign gnt_o = gnt_q;

  // R3
  single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own_q));
  // R2
  gnt_sets_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_q) |-> (own_q == gnt_q) && ($past(own_q) == '0));
  // R7
  rel_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(own_q & rel_i)) |=> (own_q == '0) && (gnt_q == '0));
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|own_q) && !(|(own_q & rel_i))) |=> $stable(own_q));
endmodule

// File: rtl/xbar_merge.sv
`timescale 1ns/1ps
module xbar_merge #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned DW   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN*DW-1:0] in_data_i,
  input  logic [N_IN-1:0]    own_i,
  output logic [DW-1:0]      out_o
);
  always_comb begin
    out_o = '0;
    for (int i = 0; i < N_IN; i++)
      out_o = out_o | (in_data_i[i*DW +: DW] & {DW{own_i[i]}});
  end

  // R3
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_i == '0) |-> (out_o == '0));
endmodule

// File: rtl/xbar_fabric.sv
`timescale 1ns/1ps
module xbar_fabric #(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned DW    = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IN*DW-1:0]    in_data_i,
  input  logic [N_IN*N_OUT-1:0] req_i,
  input  logic [N_IN*N_OUT-1:0] rel_i,
  output logic [N_IN*N_OUT-1:0] gnt_o,
  output logic [N_OUT*DW-1:0]   out_data_o
);
  import xbar_pkg::*;

  localparam int unsigned NPAIR = N_IN * N_OUT;

  logic [N_IN-1:0] col_req [N_OUT];
  logic [N_IN-1:0] col_rel [N_OUT];
  logic [N_IN-1:0] col_own [N_OUT];
  logic [N_IN-1:0] col_gnt [N_OUT];

  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    for (genvar i = 0; i < N_IN; i++) begin : g_src
      assign col_req[o][i] = req_i[pair_idx(i, o, N_OUT)];
      assign col_rel[o][i] = rel_i[pair_idx(i, o, N_OUT)];
      assign gnt_o[pair_idx(i, o, N_OUT)] = col_gnt[o][i];
    end

    xbar_col_arb #(.N_IN(N_IN)) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (col_req[o]),
      .rel_i (col_rel[o]),
      .own_o (col_own[o]),
      .gnt_o (col_gnt[o])
    );

    xbar_merge #(.N_IN(N_IN), .DW(DW)) u_merge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .in_data_i(in_data_i),
      .own_i    (col_own[o]),
      .out_o    (out_data_o[o*DW +: DW])
    );
  end

  // R8: no grant may land on a column that was held in the previous cycle
  logic [NPAIR-1:0] held_prev;
  always_comb
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++)
        held_prev[i*N_OUT+o] = |col_own[o];

  // R8
  no_steal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> ((gnt_o & $past(held_prev)) == '0));
endmodule

// File: tb/sim_xbar_fabric.sv
`timescale 1ns/1ps
module sim_xbar_fabric;
  localparam int NI = 8, NO = 8, DW = 32, NP = NI * NO;

  logic clk = 0, rst_n = 0;
  logic [NI*DW-1:0] din = '0;
  logic [NP-1:0] req = '0, rel = '0;
  logic [NP-1:0] gnt;
  logic [NO*DW-1:0] dout;

  always #2 clk = ~clk;

  xbar_fabric #(.N_IN(NI), .N_OUT(NO), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(din), .req_i(req), .rel_i(rel),
    .gnt_o(gnt), .out_data_o(dout));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: owner and priority list per column
  int own_m [NO];
  int ord_m [NO][NI];
  logic [NP-1:0] gnt_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_m = '0;
      for (int o = 0; o < NO; o++) begin
        own_m[o] = -1;
        for (int k = 0; k < NI; k++) ord_m[o][k] = k;
      end
    end else begin
      gnt_m = '0;
      for (int o = 0; o < NO; o++) begin
        if (own_m[o] >= 0) begin
          if (rel[own_m[o]*NO+o]) begin
            int m, p;
            m = own_m[o];
            p = 0;
            for (int k = 0; k < NI; k++) if (ord_m[o][k] == m) p = k;
            for (int k = p; k < NI - 1; k++) ord_m[o][k] = ord_m[o][k+1];
            ord_m[o][NI-1] = m;
            own_m[o] = -1;
          end
        end else begin
          for (int k = 0; k < NI; k++)
            if (own_m[o] < 0 && req[ord_m[o][k]*NO+o]) begin
              own_m[o] = ord_m[o][k];
              gnt_m[ord_m[o][k]*NO+o] = 1'b1;
            end
        end
      end
    end
  end

  always @(negedge clk) begin
    #0.3;
    if (rst_n && !done) begin
      check("R2 grant vs model", 64'(gnt), 64'(gnt_m));
      for (int o = 0; o < NO; o++)
        check("R3 column data vs model", 64'(dout[o*DW +: DW]),
              own_m[o] < 0 ? 64'd0 : 64'(din[own_m[o]*DW +: DW]));
    end
  end

  function automatic logic [NP-1:0] pb(int i, int o);
    logic [NP-1:0] v = '0;
    v[i*NO+o] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] col(int o);
    return 64'(dout[o*DW +: DW]);
  endfunction

  function automatic logic [63:0] src(int i);
    return 64'(din[i*DW +: DW]);
  endfunction

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) din[i*DW +: DW] = 32'hA500_0000 + 32'h0001_0203 * (i + 1);
    tick(); tick();
    check("R1 gnt in reset", 64'(gnt), 0);
    check("R1 data in reset", 64'(|dout), 0);
    rst_n = 1;
    tick();
    check("R1 gnt after reset", 64'(gnt), 0);
    check("R1 data after reset", 64'(|dout), 0);

    // contention on column 2: low index wins after reset
    req = pb(0, 2) | pb(3, 2);
    tick();
    check("R9 R10 reset order grant", 64'(gnt), 64'(pb(0, 2)));
    check("R2 winner data", col(2), src(0));
    req = pb(3, 2);
    tick();
    check("R8 held column no grant", 64'(gnt), 0);
    check("R6 persists without req", col(2), src(0));
    rel = pb(5, 2);
    tick();
    check("R8 foreign release ignored", col(2), src(0));
    // owner release meets waiting request
    rel = pb(0, 2);
    tick();
    check("R7 released column zero", col(2), 0);
    check("R7 no grant at release edge", 64'(gnt), 0);
    rel = '0;
    tick();
    check("R7 grant one edge later", 64'(gnt), 64'(pb(3, 2)));
    check("R7 new owner data", col(2), src(3));
    req = '0;
    rel = pb(3, 2);
    tick();
    rel = '0;

    // LRG on column 4
    req = pb(1, 4) | pb(6, 4);
    tick();
    check("R9 first pick on col4", 64'(gnt), 64'(pb(1, 4)));
    req = '0;
    rel = pb(1, 4);
    tick();
    rel = '0;
    req = pb(1, 4) | pb(6, 4);
    tick();
    check("R9 released source demoted", 64'(gnt), 64'(pb(6, 4)));
    req = '0;
    rel = pb(6, 4);
    tick();
    rel = '0;

    // multicast plus an independent column
    req = pb(2, 0) | pb(2, 1) | pb(2, 7) | pb(4, 5);
    tick();
    check("R5 R4 grants", 64'(gnt), 64'(pb(2, 0) | pb(2, 1) | pb(2, 7) | pb(4, 5)));
    check("R5 col0", col(0), src(2));
    check("R5 col1", col(1), src(2));
    check("R5 col7", col(7), src(2));
    check("R4 col5", col(5), src(4));
    req = '0;
    rel = pb(2, 0) | pb(2, 1) | pb(2, 7) | pb(4, 5);
    tick();
    rel = '0;
    check("R3 all idle zero", 64'(|dout), 0);

    // random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NI; i++) din[i*DW +: DW] = $urandom;
      req = {$urandom, $urandom} & {$urandom, $urandom};
      rel = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      tick();
    end
    req = '0;
    rel = '1;
    tick();
    rel = '0;
    tick();
    check("R7 all released", 64'(|dout), 0);

    done = 1;
    summary();
  end
endmodule